// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits beside a parallel flash array controller and watches its write bus: a one-cycle write strobe with a word address and a data word. It recognizes the multi-write command sequences that flash-style parts accept. Each sequence opens with two unlock writes (AAh to 555h, then 55h to 2AAh), and a command byte written to 555h follows. Program adds one write that carries the target address and data. Both erase forms repeat the unlock after an 80h byte. An unlock-bypass mode shortens program and erase to two writes each. Erase suspend and resume are qualified by bank.

For every complete sequence the decoder emits a registered strobe lasting one clock. The strobe carries a command code, the address and data of the final write, and the bank field of that address. The decoder also keeps a mode register: read, autoselect, CFI, bypass, erasing or suspended. The array and the embedded algorithms are outside the block. A `busy` input stands in for them. While in autoselect mode, a read port returns the manufacturer code.

The write bus has no back-pressure. Every strobed write is consumed in the cycle it arrives, and a write that is not part of any legal sequence is dropped without a response.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (read), and `cmd_valid` and `id_valid` are low.
- R2: Unlock and command writes compare only address bits 11:0 and data bits 7:0. Unlock, then A0h, then one write of any address and data produces code 2 (program), with that write's address and full data on `cmd_addr` and `cmd_data`.
- R3: Unlock, 80h, then AAh@555h and 55h@2AAh, followed by a final write. 10h@555h gives code 3 (chip erase). 30h at any address gives code 4 (sector erase), with `cmd_bank` taken from address bits 18:17. Either one sets mode 4 (erasing).
- R4: A write that breaks an expected sequence produces no strobe, leaves the mode unchanged and returns the sequence to its start.
- R5: F0h gives code 1 (reset) and returns read mode from read, autoselect or CFI. It keeps mode 5 in suspended mode and mode 3 in bypass mode, and it abandons any partial sequence. The data write of a program sequence is never taken as a reset.
- R6: Unlock then 90h gives code 5 and mode 1 (autoselect). In that mode, a read at offset 00h returns `id_data` 01h with `id_valid` one clock later. Any other offset returns 00h.
- R7: 98h written to address 55h gives code 6 and mode 2 (CFI), but only from read or autoselect mode. The same write in bypass mode is ignored.
- R8: Unlock then 20h gives code 7 and mode 3 (bypass). In bypass mode, A0h then one write gives code 2, and 80h then 10h gives code 3. 90h then 00h gives code 8 and returns mode 0. Any other second byte is a broken sequence.
- R9: B0h gives code 9 (suspend) and mode 5, but only during a sector erase and only when address bits 18:17 match the erased bank. It is ignored during a chip erase or when the bank differs.
- R10: In suspended mode, 30h at the suspended bank gives code 10 (resume) and mode 4. The same byte at another bank is ignored.
- R11: While `busy` is high, all writes are ignored outside erasing mode. In erasing mode only a suspend is honored, and `busy` does not block it.
- R12: An erase ends on the first clock that samples `busy` low after `busy` was seen high. Mode then returns to 0, or to 3 if the erase began in bypass mode.
- R13: `cmd_valid` is high for exactly the clock after the accepted final write, and never without a write in the prior clock. Codes are 1 reset, 2 program, 3 chip erase, 4 sector erase, 5 autoselect, 6 CFI, 7 bypass entry, 8 bypass exit, 9 suspend, 10 resume. Modes are 0 read, 1 autoselect, 2 CFI, 3 bypass, 4 erasing, 5 suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 19 | Word address of the write |
| wr_data | input | 32 | Data of the write |
| busy | input | 1 | Embedded operation in progress |
| rd_en | input | 1 | Read strobe for the identifier port |
| rd_offset | input | 8 | Offset within the bank for the identifier read |
| cmd_valid | output | 1 | Decoded command strobe, one clock |
| cmd_code | output | 4 | Decoded command code |
| cmd_addr | output | 19 | Address of the final write of the sequence |
| cmd_data | output | 32 | Data of the final write of the sequence |
| cmd_bank | output | 2 | Bank field of the final write address |
| mode | output | 3 | Current decoder mode |
| id_valid | output | 1 | Identifier read result valid |
| id_data | output | 8 | Identifier read result |

## Verification
On every cycle, the assertions check the following. A strobe is always preceded by a write. No strobe follows a busy cycle outside erasing. Suspend, resume and CFI strobes arise only from the modes that permit them. Erase strobes leave the decoder in erasing mode, and the mode stays within its six legal values. The bench's scenarios are the only evidence for other properties. These include that the unlock compare ignores high address and data bits (the bench sweeps all 256 command bytes to show this), and that broken sequences leave no trace. They also include the bank match on suspend and resume, the F0h priority rules, and the mode return once an erase completes.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    M_READ = 3'd0, M_AUTOSEL = 3'd1, M_CFI = 3'd2,
    M_BYPASS = 3'd3, M_ERASING = 3'd4, M_SUSPENDED = 3'd5
  } mode_e;

  typedef enum logic [3:0] {
    C_NONE = 4'd0, C_RESET = 4'd1, C_PROGRAM = 4'd2, C_CHIP_ERASE = 4'd3,
    C_SECTOR_ERASE = 4'd4, C_AUTOSEL = 4'd5, C_CFI = 4'd6,
    C_BYP_ENTER = 4'd7, C_BYP_EXIT = 4'd8, C_SUSPEND = 4'd9, C_RESUME = 4'd10
  } cmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_U1, S_U2, S_PROG, S_E1, S_E2, S_E3, S_BPROG, S_BERASE, S_BEXIT
  } step_e;

  localparam logic [7:0] OP_KEY1    = 8'hAA;
  localparam logic [7:0] OP_KEY2    = 8'h55;
  localparam logic [7:0] OP_PROG    = 8'hA0;
  localparam logic [7:0] OP_ERASE   = 8'h80;
  localparam logic [7:0] OP_CHIP    = 8'h10;
  localparam logic [7:0] OP_SECTOR  = 8'h30;
  localparam logic [7:0] OP_BYPASS  = 8'h20;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_CFI     = 8'h98;
  localparam logic [7:0] OP_RESET   = 8'hF0;
  localparam logic [7:0] OP_SUSPEND = 8'hB0;
  localparam logic [7:0] OP_EXIT2   = 8'h00;
endpackage

// File: rtl/fcd_cycle_match.sv
module fcd_cycle_match #(
  parameter int CMP_W = 12,
  parameter logic [CMP_W-1:0] KEY_A = 12'h555,
  parameter logic [CMP_W-1:0] KEY_B = 12'h2AA,
  parameter logic [CMP_W-1:0] CFI_A = 12'h055
) (
  input  logic [CMP_W-1:0] cmp_addr,
  input  logic [7:0]       cmp_byte,
  output logic             at_a,
  output logic             at_b,
  output logic             at_cfi,
  output logic [7:0]       op
);
  assign at_a   = (cmp_addr == KEY_A);
  assign at_b   = (cmp_addr == KEY_B);
  assign at_cfi = (cmp_addr == CFI_A);
  assign op     = cmp_byte;
endmodule

// File: rtl/fcd_id_read.sv
module fcd_id_read #(
  parameter int OFF_W = 8,
  parameter logic [7:0] MFR_CODE = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [OFF_W-1:0] rd_offset,
  input  logic             in_autosel,
  output logic             id_valid,
  output logic [7:0]       id_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_valid <= 1'b0;
      id_data  <= '0;
    end else begin
      id_valid <= rd_en && in_autosel;
      id_data  <= (rd_offset == '0) ? MFR_CODE : 8'h00;
    end
  end

  p_id_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |-> $past(rd_en));
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 32,
  parameter int BANK_W = 2,
  localparam int BANK_LSB = ADDR_W - BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              busy,
  input  logic              at_a,
  input  logic              at_b,
  input  logic              at_cfi,
  input  logic [7:0]        op,
  output logic              cmd_valid,
  output cmd_e              cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic [BANK_W-1:0] cmd_bank,
  output mode_e             mode
);
  step_e step_q, step_d;
  mode_e mode_q, mode_d;
  cmd_e  code_d;
  logic  fire;
  logic  ers_start, ers_sec, resume;
  logic  ers_sector_q, ret_byp_q, seen_busy_q;
  logic [BANK_W-1:0] ers_bank_q;
  logic [BANK_W-1:0] wbank;
  logic  rst_op;

  assign wbank  = addr[BANK_LSB +: BANK_W];
  assign rst_op = (op == OP_RESET);

  always_comb begin
    step_d = step_q; mode_d = mode_q; fire = 1'b0; code_d = C_NONE;
    ers_start = 1'b0; ers_sec = 1'b0; resume = 1'b0;
    if (mode_q == M_ERASING) begin
      step_d = S_IDLE;
      if (wr_en && ers_sector_q && op == OP_SUSPEND && wbank == ers_bank_q) begin
        fire = 1'b1; code_d = C_SUSPEND; mode_d = M_SUSPENDED;
      end else if (seen_busy_q && !busy) begin
        mode_d = ret_byp_q ? M_BYPASS : M_READ;
      end
    end else if (wr_en && !busy) begin
      if (rst_op && step_q != S_PROG && step_q != S_BPROG) begin
        fire = 1'b1; code_d = C_RESET; step_d = S_IDLE;
        if (mode_q != M_BYPASS && mode_q != M_SUSPENDED) mode_d = M_READ;
      end else begin
        case (mode_q)
          M_SUSPENDED: if (op == OP_SECTOR && wbank == ers_bank_q) begin
            fire = 1'b1; code_d = C_RESUME; mode_d = M_ERASING; resume = 1'b1;
          end
          M_AUTOSEL: if (at_cfi && op == OP_CFI) begin
            fire = 1'b1; code_d = C_CFI; mode_d = M_CFI;
          end
          M_BYPASS: begin
            step_d = S_IDLE;
            case (step_q)
              S_BPROG: begin fire = 1'b1; code_d = C_PROGRAM; end
              S_BERASE: if (op == OP_CHIP) begin
                fire = 1'b1; code_d = C_CHIP_ERASE; mode_d = M_ERASING; ers_start = 1'b1;
              end
              S_BEXIT: if (op == OP_EXIT2) begin
                fire = 1'b1; code_d = C_BYP_EXIT; mode_d = M_READ;
              end
              default: begin
                if (op == OP_PROG)       step_d = S_BPROG;
                else if (op == OP_ERASE) step_d = S_BERASE;
                else if (op == OP_IDENT) step_d = S_BEXIT;
              end
            endcase
          end
          M_READ: begin
            step_d = S_IDLE;
            case (step_q)
              S_IDLE: begin
                if (at_a && op == OP_KEY1) step_d = S_U1;
                else if (at_cfi && op == OP_CFI) begin
                  fire = 1'b1; code_d = C_CFI; mode_d = M_CFI;
                end
              end
              S_U1: if (at_b && op == OP_KEY2) step_d = S_U2;
              S_U2: if (at_a) begin
                case (op)
                  OP_PROG:   step_d = S_PROG;
                  OP_ERASE:  step_d = S_E1;
                  OP_BYPASS: begin fire = 1'b1; code_d = C_BYP_ENTER; mode_d = M_BYPASS; end
                  OP_IDENT:  begin fire = 1'b1; code_d = C_AUTOSEL; mode_d = M_AUTOSEL; end
                  default:   step_d = S_IDLE;
                endcase
              end
              S_PROG: begin fire = 1'b1; code_d = C_PROGRAM; end
              S_E1: if (at_a && op == OP_KEY1) step_d = S_E2;
              S_E2: if (at_b && op == OP_KEY2) step_d = S_E3;
              S_E3: begin
                if (at_a && op == OP_CHIP) begin
                  fire = 1'b1; code_d = C_CHIP_ERASE; mode_d = M_ERASING; ers_start = 1'b1;
                end else if (op == OP_SECTOR) begin
                  fire = 1'b1; code_d = C_SECTOR_ERASE; mode_d = M_ERASING;
                  ers_start = 1'b1; ers_sec = 1'b1;
                end
              end
              default: step_d = S_IDLE;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= S_IDLE; mode_q <= M_READ;
      cmd_valid <= 1'b0; cmd_code <= C_NONE;
      cmd_addr <= '0; cmd_data <= '0; cmd_bank <= '0;
      ers_sector_q <= 1'b0; ers_bank_q <= '0; ret_byp_q <= 1'b0; seen_busy_q <= 1'b0;
    end else begin
      step_q    <= step_d;
      mode_q    <= mode_d;
      cmd_valid <= fire;
      if (fire) begin
        cmd_code <= code_d; cmd_addr <= addr; cmd_data <= data; cmd_bank <= wbank;
      end
      if (ers_start) begin
        ers_sector_q <= ers_sec;
        ers_bank_q   <= wbank;
        ret_byp_q    <= (mode_q == M_BYPASS);
        seen_busy_q  <= 1'b0;
      end else if (resume) begin
        seen_busy_q  <= 1'b0;
      end else if (mode_q == M_ERASING && busy) begin
        seen_busy_q  <= 1'b1;
      end
    end
  end

  assign mode = mode_q;

  p_strobe_after_write_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(wr_en));
  p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && $past(mode_q) != M_ERASING) |-> !cmd_valid);
  p_suspend_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == C_SUSPEND) |->
      ($past(mode_q) == M_ERASING && $past(ers_sector_q) && mode_q == M_SUSPENDED));
  p_resume_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == C_RESUME) |->
      ($past(mode_q) == M_SUSPENDED && mode_q == M_ERASING));
  p_erase_sets_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_code == C_CHIP_ERASE || cmd_code == C_SECTOR_ERASE)) |->
      mode_q == M_ERASING);
  p_cfi_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == C_CFI) |->
      ($past(mode_q) == M_READ || $past(mode_q) == M_AUTOSEL));
  p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q inside {M_READ, M_AUTOSEL, M_CFI, M_BYPASS, M_ERASING, M_SUSPENDED});
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 32,
  parameter int BANK_W = 2,
  parameter int CMP_W  = 12,
  parameter int OFF_W  = 8,
  parameter logic [7:0] MFR_CODE = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic              rd_en,
  input  logic [OFF_W-1:0]  rd_offset,
  output logic              cmd_valid,
  output logic [3:0]        cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [2:0]        mode,
  output logic              id_valid,
  output logic [7:0]        id_data
);
  logic       at_a, at_b, at_cfi;
  logic [7:0] op;
  cmd_e       code_w;
  mode_e      mode_w;

  fcd_cycle_match #(.CMP_W(CMP_W)) match_i (
    .cmp_addr(wr_addr[CMP_W-1:0]), .cmp_byte(wr_data[7:0]),
    .at_a(at_a), .at_b(at_b), .at_cfi(at_cfi), .op(op)
  );

  fcd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(wr_addr), .data(wr_data),
    .busy(busy), .at_a(at_a), .at_b(at_b), .at_cfi(at_cfi), .op(op),
    .cmd_valid(cmd_valid), .cmd_code(code_w), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_bank(cmd_bank), .mode(mode_w)
  );

  fcd_id_read #(.OFF_W(OFF_W), .MFR_CODE(MFR_CODE)) id_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_offset(rd_offset),
    .in_autosel(mode_w == M_AUTOSEL), .id_valid(id_valid), .id_data(id_data)
  );

  assign cmd_code = code_w;
  assign mode     = mode_w;
endmodule

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, busy = 1'b0, rd_en = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_offset = '0;
  logic        cmd_valid, id_valid;
  logic [3:0]  cmd_code;
  logic [18:0] cmd_addr;
  logic [31:0] cmd_data;
  logic [1:0]  cmd_bank;
  logic [2:0]  mode;
  logic [7:0]  id_data;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic o_v; logic [3:0] o_c; logic [18:0] o_a; logic [31:0] o_d; logic [1:0] o_b; logic [2:0] o_m;

  flash_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .rd_en(rd_en), .rd_offset(rd_offset), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_bank(cmd_bank),
    .mode(mode), .id_valid(id_valid), .id_data(id_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [18:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    o_v = cmd_valid; o_c = cmd_code; o_a = cmd_addr; o_d = cmd_data; o_b = cmd_bank; o_m = mode;
  endtask

  task automatic unl3(input logic [7:0] c);
    wr(19'h555, 32'hAA); wr(19'h2AA, 32'h55); wr(19'h555, {24'h0, c});
  endtask

  // observed strobe+mode packed as {valid, code, mode}
  function automatic logic [31:0] obs();
    return {24'h0, o_v, o_c, o_m};
  endfunction
  function automatic logic [31:0] ex(input logic v, input logic [3:0] c, input logic [2:0] m);
    return {24'h0, v, c, m};
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    chk("R1 mode", {29'h0, mode}, 0);
    chk("R1 strobes", {30'h0, cmd_valid, id_valid}, 0);

    // R2 R4 R6 R8 sweep of every command byte with noisy high bits
    for (int d = 0; d < 256; d++) begin
      logic [7:0] b; logic v; logic [3:0] c; logic [2:0] m;
      b = d[7:0];
      wr({b[6:0], 12'h555}, {b, b, b, 8'hAA});
      chk("R2 unlock1 silent", {31'h0, o_v}, 0);
      wr({b[6:0], 12'h2AA}, {~b, b, b, 8'h55});
      wr({b[6:0], 12'h555}, {b, b, b, b});
      v = (b == 8'h20 || b == 8'h90 || b == 8'hF0);
      c = (b == 8'h20) ? 4'd7 : (b == 8'h90) ? 4'd5 : (b == 8'hF0) ? 4'd1 : 4'd0;
      m = (b == 8'h20) ? 3'd3 : (b == 8'h90) ? 3'd1 : 3'd0;
      if (v) chk("R2/R4 command byte", obs(), ex(v, c, m));
      else   chk("R4 no strobe", {28'h0, o_v, o_m}, {28'h0, 1'b0, 3'd0});
      if (b == 8'hA0) begin
        wr({b[2:0], 16'h1234 ^ {8'h0, b}}, {b, 8'h5A, ~b, b});
        chk("R2 program code", obs(), ex(1, 2, 0));
        chk("R2 program addr", {13'h0, o_a}, {13'h0, b[2:0], 16'h1234 ^ {8'h0, b}});
        chk("R2 program data", o_d, {b, 8'h5A, ~b, b});
      end else if (b == 8'h90) begin
        rd_en = 1'b1; rd_offset = 8'h00; tick(); rd_en = 1'b0;
        chk("R6 id offset 0", {23'h0, id_valid, id_data}, {23'h0, 1'b1, 8'h01});
        rd_en = 1'b1; rd_offset = 8'h01; tick(); rd_en = 1'b0;
        chk("R6 id offset 1", {23'h0, id_valid, id_data}, {23'h0, 1'b1, 8'h00});
        wr(19'h0, 32'hF0);
      end else if (b == 8'h20) begin
        wr(19'h0, 32'h90); wr(19'h0, 32'h00);
        chk("R8 bypass exit", obs(), ex(1, 8, 0));
      end else if (b != 8'hF0) begin
        wr(19'h7FFFF, 32'hF0);
      end
      chk("R5 back to read", {29'h0, mode}, 0);
    end

    // R4 broken unlock then proof of idle via CFI
    wr(19'h555, 32'hAA); wr(19'h2AB, 32'h55);
    chk("R4 bad address", {31'h0, o_v}, 0);
    wr(19'h555, 32'hA0);
    chk("R4 restart", {31'h0, o_v}, 0);
    wr(19'h055, 32'h98);
    chk("R7 cfi from read", obs(), ex(1, 6, 2));
    wr(19'h555, 32'hAA);
    chk("R7 cfi ignores unlock", obs(), ex(0, 6, 2));
    wr(19'h0, 32'hF0);
    chk("R5 reset from cfi", obs(), ex(1, 1, 0));
    // R4 break inside erase unlock
    unl3(8'h80); wr(19'h555, 32'hAA); wr(19'h2AA, 32'h54);
    chk("R4 erase break", obs(), ex(0, 1, 0));
    wr(19'h555, 32'h10);
    chk("R4 no late erase", obs(), ex(0, 1, 0));
    // R5 F0 as program data
    unl3(8'hA0); wr(19'h00123, 32'h000000F0);
    chk("R5 program data F0", obs(), ex(1, 2, 0));
    chk("R5 program data value", o_d, 32'hF0);
    // R7 CFI from autoselect
    unl3(8'h90); wr(19'h055, 32'h98);
    chk("R7 cfi from autosel", obs(), ex(1, 6, 2));
    wr(19'h0, 32'hF0);

    // R3 R9 R12 chip erase
    unl3(8'h80); wr(19'h555, 32'hAA); wr(19'h2AA, 32'h55); wr(19'h555, 32'h10);
    chk("R3 chip erase", obs(), ex(1, 3, 4));
    wr(19'h0, 32'hB0);
    chk("R9 no suspend in chip erase", {28'h0, o_v, o_m}, {28'h0, 1'b0, 3'd4});
    busy = 1'b1; tick();
    wr(19'h0, 32'hF0);
    chk("R11 reset ignored while erasing", {28'h0, o_v, o_m}, {28'h0, 1'b0, 3'd4});
    busy = 1'b0; tick();
    chk("R12 erase done", {29'h0, mode}, 0);

    // R3 R9 R10 sector erase with bank checks
    unl3(8'h80); wr(19'h555, 32'hAA); wr(19'h2AA, 32'h55);
    wr({2'b10, 6'h15, 11'h0}, 32'h30);
    chk("R3 sector erase", obs(), ex(1, 4, 4));
    chk("R3 sector bank", {30'h0, o_b}, 2);
    busy = 1'b1; tick();
    wr({2'b01, 17'h0}, 32'hB0);
    chk("R9 wrong bank suspend", {28'h0, o_v, o_m}, {28'h0, 1'b0, 3'd4});
    wr({2'b10, 17'h0}, 32'hB0);
    chk("R9 R11 suspend while busy", obs(), ex(1, 9, 5));
    busy = 1'b0; tick(); tick();
    chk("R9 stays suspended", {29'h0, mode}, 5);
    wr(19'h0, 32'hF0);
    chk("R5 reset keeps suspend", obs(), ex(1, 1, 5));
    wr({2'b01, 17'h0}, 32'h30);
    chk("R10 wrong bank resume", {28'h0, o_v, o_m}, {28'h0, 1'b0, 3'd5});
    wr({2'b10, 17'h0}, 32'h30);
    chk("R10 resume", obs(), ex(1, 10, 4));
    busy = 1'b1; tick(); busy = 1'b0; tick();
    chk("R12 sector done", {29'h0, mode}, 0);

    // R11 busy outside erase
    busy = 1'b1; unl3(8'h90);
    chk("R11 busy ignores", {28'h0, o_v, o_m}, {28'h0, 1'b0, 3'd0});
    busy = 1'b0;
    wr(19'h055, 32'h98);
    chk("R11 idle after busy", obs(), ex(1, 6, 2));
    wr(19'h0, 32'hF0);

    // R8 R12 bypass mode
    unl3(8'h20);
    wr(19'h055, 32'h98);
    chk("R7 cfi ignored in bypass", {28'h0, o_v, o_m}, {28'h0, 1'b0, 3'd3});
    wr(19'h0, 32'hA0); wr(19'h4_5678, 32'hDEADBEEF);
    chk("R8 bypass program", obs(), ex(1, 2, 3));
    chk("R8 bypass program data", o_d, 32'hDEADBEEF);
    wr(19'h0, 32'hF0);
    chk("R5 reset in bypass", obs(), ex(1, 1, 3));
    wr(19'h0, 32'h80); wr(19'h0, 32'h11);
    chk("R8 bypass erase break", {28'h0, o_v, o_m}, {28'h0, 1'b0, 3'd3});
    wr(19'h0, 32'h80); wr(19'h0, 32'h10);
    chk("R8 bypass chip erase", obs(), ex(1, 3, 4));
    busy = 1'b1; tick(); busy = 1'b0; tick();
    chk("R12 return to bypass", {29'h0, mode}, 3);
    wr(19'h0, 32'h90); wr(19'h0, 32'h01);
    chk("R8 bad exit byte", {28'h0, o_v, o_m}, {28'h0, 1'b0, 3'd3});
    wr(19'h0, 32'h90); wr(19'h0, 32'h00);
    chk("R8 bypass exit", obs(), ex(1, 8, 0));
    tick();
    chk("R13 strobe one clock", {31'h0, cmd_valid}, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule